// File: doc/BRIEF.md
# Floppy Controller Burst-Mode Wait Generator

This block sits between an 8-bit CPU I/O bus and a floppy disk controller chip. It decodes an eight-address I/O window and holds one control register at the window's base. The upper four addresses of the window are passed through to the controller's four registers. It also conditions the controller's data-request and interrupt lines before they reach the system interrupt logic.

A slow CPU cannot poll or service interrupts fast enough at high disk data rates. For that case the block has a burst mode. In burst mode, a data-port access made while the controller has no request pending is not sent to the controller. Instead, a WAIT line holds the CPU in that bus cycle. The moment the controller raises its data request (or its interrupt), WAIT drops and the held access completes to the controller in the same cycle. Only the first data request after an interrupt is forwarded to the interrupt logic. Later requests in the same transfer are serviced through the wait mechanism alone.

Top module: `fdc_burst_gate`

## Requirements
- R1: The window is the eight addresses 0x38 to 0x3F (`addr[7:3]` equal to `BASE[7:3]`). An access outside it raises no controller strobe, no WAIT, and reads 0x00.
- R2: Offset 0 of the window is the control register. A write there loads `wdata[0]` into the DRQ-enable bit, and a read returns `{7'b0, enable}`. Burst mode is active exactly when the enable bit is 0. Offsets 1 to 3 read 0x00.
- R3: Offsets 4 to 7 are forwarded to the controller in the same cycle. `fdc_a` carries `addr[1:0]`, `fdc_rd`/`fdc_wr` follow `rd`/`wr`, and a read returns `fdc_rdata`. The data port is offset 7 (`fdc_a` = 3).
- R4: In burst mode, a read or write of the data port while `drq_in` and `irq_in` are both low asserts `wait_o` combinationally. Such an access raises neither `fdc_rd` nor `fdc_wr`, and it reads 0x00.
- R5: While such an access is held, `wait_o` falls in the very cycle `drq_in` or `irq_in` rises. The held access then reaches the controller in that same cycle.
- R6: A data-port access made while `drq_in` or `irq_in` is already high passes straight to the controller with no wait, in either mode.
- R7: When the enable bit is 1, `drq_o` equals `drq_in` and `wait_o` stays low.
- R8: In burst mode, `drq_o` equals `drq_in` only while the request counter is zero, and is low otherwise. The counter is a `CNT_W`-bit value that saturates at its maximum. It increments on the clock edge after each falling edge of `drq_in` seen in burst mode.
- R9: `irq_o` equals `irq_in`. Each clock edge with `irq_in` high clears the request counter, so the next request is forwarded again.
- R10: During reset `wait_o`, `drq_o` and `irq_o` are low. Reset clears the enable bit (burst mode) and the request counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | CPU I/O address |
| rd | input | 1 | CPU read strobe, held for the whole access |
| wr | input | 1 | CPU write strobe, held for the whole access |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Read data returned to the CPU |
| wait_o | output | 1 | WAIT to the CPU, stretches the current access |
| fdc_rd | output | 1 | Read strobe to the controller |
| fdc_wr | output | 1 | Write strobe to the controller |
| fdc_a | output | 2 | Controller register select |
| fdc_rdata | input | 8 | Read data from the controller |
| drq_in | input | 1 | Data request from the controller |
| irq_in | input | 1 | Interrupt from the controller |
| drq_o | output | 1 | Qualified data request to the interrupt logic |
| irq_o | output | 1 | Qualified interrupt to the interrupt logic |

## Verification
WAIT, the controller strobes, read data and both qualified request lines are combinational. They are due in the same cycle as the stimulus that causes them. The enable bit and the request counter change only at the next rising edge. The bench drives inputs just after a rising edge and keeps a behavioural model whose state advances on the same edge. It compares every output at the falling edge, so a same-cycle result and a next-edge state change are each sampled in the cycle they are due.

// File: rtl/fdc_burst_gate.sv
module fdc_burst_gate #(
  parameter logic [7:0] BASE  = 8'h38,
  parameter int         CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       wait_o,
  output logic       fdc_rd,
  output logic       fdc_wr,
  output logic [1:0] fdc_a,
  input  logic [7:0] fdc_rdata,
  input  logic       drq_in,
  input  logic       irq_in,
  output logic       drq_o,
  output logic       irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             drq_en;
  logic             drq_prev;
  logic [CNT_W-1:0] drq_cnt;

  wire [2:0] off     = addr[2:0];
  wire       in_win  = addr[7:3] == BASE[7:3];
  wire       ctl_hit = in_win && off == 3'd0;
  wire       fdc_hit = in_win && off[2];
  wire       dp_hit  = fdc_hit && off[1:0] == 2'b11;
  wire       burst   = !drq_en;
  wire       held    = burst && dp_hit && (rd || wr) && !drq_in && !irq_in;

  assign wait_o = rst_n && held;
  assign fdc_rd = rd && fdc_hit && !held;
  assign fdc_wr = wr && fdc_hit && !held;
  assign fdc_a  = off[1:0];
  assign drq_o  = rst_n && drq_in && (burst ? drq_cnt == '0 : 1'b1);
  assign irq_o  = rst_n && irq_in;

  always_comb begin
    if (!rd || held)  rdata = 8'h00;
    else if (fdc_hit) rdata = fdc_rdata;
    else if (ctl_hit) rdata = {7'b0, drq_en};
    else              rdata = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drq_en   <= 1'b0;
      drq_prev <= 1'b0;
      drq_cnt  <= '0;
    end else begin
      if (wr && ctl_hit) drq_en <= wdata[0];
      drq_prev <= drq_in;
      if (irq_in)
        drq_cnt <= '0;
      else if (burst && drq_prev && !drq_in && drq_cnt != CNT_MAX)
        drq_cnt <= drq_cnt + CNT_W'(1);
    end
  end

  p_hold_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (!fdc_rd && !fdc_wr && rdata == 8'h00));

  p_release_completes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wait_o) && !wait_o && $past(rd) && rd && $stable(addr)) |-> fdc_rd);

  p_nonburst_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drq_en |-> (!wait_o && drq_o == drq_in));

  p_later_drq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!drq_en && drq_cnt != '0) |-> !drq_o);

  p_cnt_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drq_cnt == CNT_MAX && !irq_in) |=> drq_cnt == CNT_MAX);

  p_irq_clears_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |=> drq_cnt == '0);

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == irq_in);
endmodule

// File: tb/sim_fdc_burst_gate.sv
module sim_fdc_burst_gate;
  localparam int CNT_W = 2;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic       clk = 0, rst_n = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       rd = 0, wr = 0, drq_in = 0, irq_in = 0;
  logic [7:0] rdata, fdc_rdata;
  logic       wait_o, fdc_rd, fdc_wr, drq_o, irq_o;
  logic [1:0] fdc_a;

  int checks = 0, errors = 0;
  int m_en = 0, m_cnt = 0;
  bit m_prev = 0;

  always #5 clk = ~clk;

  assign fdc_rdata = {6'b101010, fdc_a};

  fdc_burst_gate #(.BASE(8'h38), .CNT_W(CNT_W)) u0 (
    .clk, .rst_n, .addr, .rd, .wr, .wdata, .rdata, .wait_o,
    .fdc_rd, .fdc_wr, .fdc_a, .fdc_rdata, .drq_in, .irq_in, .drq_o, .irq_o);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cnt = 0; m_prev = 0;
    end else begin
      if (irq_in) m_cnt = 0;
      else if (m_en == 0 && m_prev && !drq_in && m_cnt < CMAX) m_cnt = m_cnt + 1;
      if (wr && addr == 8'h38) m_en = wdata[0];
      m_prev = drq_in;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit sel, blk;
    int off, e_rd;
    sel = addr[7:3] == 5'b00111;
    off = addr[2:0];
    blk = rst_n && m_en == 0 && sel && off == 7 && (rd || wr) && !drq_in && !irq_in;
    if (!rst_n) begin
      chk("R10 wait", wait_o, 0);
      chk("R10 drq", drq_o, 0);
      chk("R10 irq", irq_o, 0);
    end else begin
      chk("R4/R5 wait", wait_o, blk);
      chk("R3 fdc_rd", fdc_rd, rd && sel && off >= 4 && !blk);
      chk("R3 fdc_wr", fdc_wr, wr && sel && off >= 4 && !blk);
      if (fdc_rd || fdc_wr) chk("R3 fdc_a", fdc_a, off & 3);
      if (!rd || blk || !sel) e_rd = 0;
      else if (off >= 4) e_rd = {6'b101010, off[1:0]};
      else if (off == 0) e_rd = m_en;
      else e_rd = 0;
      chk("R3 rdata", rdata, e_rd);
      if (m_en != 0) chk("R7 drq", drq_o, drq_in);
      else chk("R8 drq", drq_o, drq_in && m_cnt == 0);
      chk("R9 irq", irq_o, irq_in);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle();
    rd = 0; wr = 0; step();
  endtask

  task automatic drq_pulse();
    drq_in = 1; step(); drq_in = 0; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drq_in = 1; irq_in = 1;
    step(3);
    irq_in = 0; drq_in = 0; rst_n = 1; step();

    addr = 8'h38; rd = 1; step();
    chk("R2 reset enable reads 0", rdata, 0);
    addr = 8'h40; wr = 1; rd = 0; wdata = 8'h01; step();
    chk("R1 outside strobe", fdc_wr, 0);
    wr = 0; rd = 1; addr = 8'h37; step();
    chk("R1 outside rdata", rdata, 0);
    addr = 8'h3A; step();
    chk("R2 unused offset", rdata, 0);
    idle();

    addr = 8'h3F; rd = 1; step(3);
    chk("R4 held", wait_o, 1);
    drq_in = 1; step();
    chk("R5 release", wait_o, 0);
    chk("R5 forwarded", fdc_rd, 1);
    idle(); drq_in = 0; step();
    drq_in = 1; step();
    chk("R8 second drq masked", drq_o, 0);
    addr = 8'h3F; rd = 1; step();
    chk("R6 pending drq passes", fdc_rd, 1);
    idle(); drq_in = 0; step();
    drq_pulse(); drq_pulse(); drq_pulse();
    drq_in = 1; step();
    chk("R8 saturated masked", drq_o, 0);
    drq_in = 0; step();
    irq_in = 1; addr = 8'h3F; wr = 1; wdata = 8'h5A; step();
    chk("R6 pending irq passes", fdc_wr, 1);
    chk("R9 irq out", irq_o, 1);
    wr = 0; irq_in = 0; step();
    drq_in = 1; step();
    chk("R9 drq after irq", drq_o, 1);
    drq_in = 0; step();

    addr = 8'h3F; wr = 1; step(2);
    irq_in = 1; step();
    chk("R5 irq releases", wait_o, 0);
    chk("R5 irq forwards", fdc_wr, 1);
    wr = 0; irq_in = 0; step();

    addr = 8'h38; wr = 1; wdata = 8'h01; step(); idle();
    addr = 8'h38; rd = 1; step();
    chk("R2 enable reads 1", rdata, 1);
    addr = 8'h3F; step();
    chk("R7 no wait", wait_o, 0);
    idle();
    for (int k = 0; k < 3; k++) begin
      drq_in = 1; step();
      chk("R7 drq follows", drq_o, 1);
      drq_in = 0; step();
    end
    for (int a = 4; a < 8; a++) begin
      addr = 8'h38 + 8'(a); rd = 1; step();
      chk("R3 register read", rdata, {6'b101010, 2'(a)});
    end
    idle();

    rst_n = 0; step(2); rst_n = 1; step();
    addr = 8'h38; rd = 1; step();
    chk("R10 enable cleared", rdata, 0);
    addr = 8'h3F; step();
    chk("R10 burst after reset", wait_o, 1);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule